// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Unit

This block arbitrates eight interrupt request lines. Each line is held in a request latch and is active low, so a cleared bit means the line is pending. Each cycle the unit finds the highest-numbered pending level. Whether that level is granted depends on a programmed current-status level and a group-select flag. When a level is granted, the unit records it in a readable level register and raises a single-cycle interrupt pulse. It then locks itself against further grants until software writes the status again.

Software or neighbouring logic updates the request latch one line at a time. Software writes the status level together with the group-select flag when it finishes servicing an interrupt. That write releases the lock.

Units can be chained into priority groups. A unit grants only while its chain-enable input is high. While it holds a grant, it pulls its chain-enable output low, which holds off lower-priority units further down the chain.

Top module: `pic8_irq_unit`

## Requirements
- R1: After synchronous reset, `irq` is 0, `level` is 0, `chain_en_out` is 1, the request latch holds all ones (nothing pending), the status level is 0, group select is 0 and the unit is unlocked.
- R2: A request update with `req_we` high writes `req_val` into bit `req_line` of the request latch and leaves the other seven bits unchanged. A value of 0 means pending and 1 means idle.
- R3: When more than one level is pending, the highest-numbered one (7 highest, 0 lowest) is the candidate for a grant.
- R4: No grant is made while the unit is locked or while `chain_en_in` is low.
- R5: With group select at 1, the candidate is granted only if its level is strictly greater than the stored status level.
- R6: With group select at 0, the candidate is granted whatever the stored status level is.
- R7: A grant is decided on a clock edge from the latch contents held before that edge. At that edge the unit loads `level` with the granted level, locks, and drives `chain_en_out` low. `irq` is then high for exactly the one cycle that follows.
- R8: A status write (`stat_we` high) stores `stat_lvl` and `stat_grp`, unlocks the unit and returns `chain_en_out` to 1. No grant is made at the edge of a status write.
- R9: Request changes made while the unit is locked are still latched, and they are arbitrated once a status write unlocks the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Single-line request update strobe |
| req_line | input | 3 | Index of the request line to update |
| req_val | input | 1 | New latch value for that line (0 = pending) |
| stat_we | input | 1 | Status write strobe |
| stat_lvl | input | 3 | Current-status level to store |
| stat_grp | input | 1 | Group-select flag to store |
| chain_en_in | input | 1 | Enable from the higher-priority neighbour |
| chain_en_out | output | 1 | Enable passed to the lower-priority neighbour |
| irq | output | 1 | One-cycle interrupt pulse |
| level | output | 3 | Most recently granted level |

## Verification
The bench sets two lines pending at once to check the scan direction. A design that scans the wrong way would report level 3 where 6 is expected. It changes requests while the unit is locked to confirm that the lock only delays those requests. A design that dropped them, or that granted through the lock, would either never pulse again or pulse early. It also programs a status level and raises the lower, equal and higher requests in turn. An off-by-one in the strict comparison would grant at the equal level. Last, it holds the chain enable low with a request pending and confirms that no pulse appears until the enable returns.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int NLVL = 8;
    localparam int LW   = $clog2(NLVL);

    typedef logic [LW-1:0] lvl_t;

    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } pick_t;

    function automatic logic wins_status(pick_t p, logic grp, lvl_t stat);
        return p.hit && (!grp || (p.lvl > stat));
    endfunction
endpackage

// File: rtl/pic8_req_latch.sv
module pic8_req_latch
    import pic8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  lvl_t            line,
    input  logic            val,
    output logic [NLVL-1:0] req_n
);
    for (genvar g = 0; g < NLVL; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                req_n[g] <= 1'b1;
            else if (we && (line == lvl_t'(g)))
                req_n[g] <= val;
        end
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
    import pic8_pkg::*;
(
    input  logic [NLVL-1:0] req_n,
    output pick_t           pick
);
    logic [NLVL-1:0] clear_above;
    logic [NLVL-1:0] win;

    assign clear_above[NLVL-1] = 1'b1;
    for (genvar g = 0; g < NLVL - 1; g++) begin : g_chain
        assign clear_above[g] = clear_above[g+1] & req_n[g+1];
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_win
        assign win[g] = ~req_n[g] & clear_above[g];
    end

    always_comb begin
        pick.hit = |win;
        pick.lvl = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (win[i])
                pick.lvl = lvl_t'(i);
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stat_we,
    input  lvl_t  stat_lvl,
    input  logic  stat_grp,
    input  logic  chain_en_in,
    input  pick_t pick,
    output lvl_t  level_q,
    output logic  irq_q,
    output logic  enlg_q,
    output lvl_t  stat_q,
    output logic  grp_q
);
    logic lock_q;
    logic grant;

    assign grant = !stat_we && !lock_q && chain_en_in && wins_status(pick, grp_q, stat_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            irq_q   <= 1'b0;
            enlg_q  <= 1'b1;
            stat_q  <= '0;
            grp_q   <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            irq_q <= grant;
            if (stat_we) begin
                stat_q <= stat_lvl;
                grp_q  <= stat_grp;
                lock_q <= 1'b0;
                enlg_q <= 1'b1;
            end else if (grant) begin
                level_q <= pick.lvl;
                lock_q  <= 1'b1;
                enlg_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic8_irq_unit.sv
module pic8_irq_unit
    import pic8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_we,
    input  logic [LW-1:0] req_line,
    input  logic          req_val,
    input  logic          stat_we,
    input  logic [LW-1:0] stat_lvl,
    input  logic          stat_grp,
    input  logic          chain_en_in,
    output logic          chain_en_out,
    output logic          irq,
    output logic [LW-1:0] level
);
    logic [NLVL-1:0] req_n;
    pick_t           pick;
    lvl_t            stat_q;
    logic            grp_q;

    pic8_req_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .we   (req_we),
        .line (req_line),
        .val  (req_val),
        .req_n(req_n)
    );

    pic8_prio u_prio (
        .req_n(req_n),
        .pick (pick)
    );

    pic8_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .stat_we    (stat_we),
        .stat_lvl   (stat_lvl),
        .stat_grp   (stat_grp),
        .chain_en_in(chain_en_in),
        .pick       (pick),
        .level_q    (level),
        .irq_q      (irq),
        .enlg_q     (chain_en_out),
        .stat_q     (stat_q),
        .grp_q      (grp_q)
    );
endmodule

// File: rtl/pic8_irq_unit_chk.sv
module pic8_irq_unit_chk
    import pic8_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic stat_we,
    input logic chain_en_in,
    input logic chain_en_out,
    input logic irq,
    input lvl_t level,
    input lvl_t stat_q,
    input logic grp_q
);
    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    // R7
    irq_holds_chain_chk: assert property (@(posedge clk) disable iff (rst) irq |-> !chain_en_out);
    // R7
    level_moves_on_grant_chk: assert property (@(posedge clk) disable iff (rst) !$stable(level) |-> irq);
    // R4
    chain_blocks_grant_chk: assert property (@(posedge clk) disable iff (rst) !chain_en_in |=> !irq);
    // R8
    stat_write_release_chk: assert property (@(posedge clk) disable iff (rst) stat_we |=> (chain_en_out && !irq));
    // R5
    strict_above_status_chk: assert property (@(posedge clk) disable iff (rst) (irq && grp_q) |-> (level > stat_q));
endmodule

bind pic8_irq_unit pic8_irq_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .stat_we     (stat_we),
    .chain_en_in (chain_en_in),
    .chain_en_out(chain_en_out),
    .irq         (irq),
    .level       (level),
    .stat_q      (stat_q),
    .grp_q       (grp_q)
);

// File: tb/pic8_irq_unit_tb_top.sv
module pic8_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_we = 1'b0;
    logic [2:0] req_line = '0;
    logic       req_val = 1'b1;
    logic       stat_we = 1'b0;
    logic [2:0] stat_lvl = '0;
    logic       stat_grp = 1'b0;
    logic       chain_en_in = 1'b1;
    logic       chain_en_out;
    logic       irq;
    logic [2:0] level;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_req[8];
    int m_lock, m_level, m_stat, m_grp, m_irq, m_enlg;

    always #5 clk = ~clk;

    pic8_irq_unit dut_i (
        .clk(clk), .rst(rst), .req_we(req_we), .req_line(req_line), .req_val(req_val),
        .stat_we(stat_we), .stat_lvl(stat_lvl), .stat_grp(stat_grp),
        .chain_en_in(chain_en_in), .chain_en_out(chain_en_out), .irq(irq), .level(level)
    );

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_req[i]) m_req[i] = 1;
            m_lock = 0; m_level = 0; m_stat = 0; m_grp = 0; m_irq = 0; m_enlg = 1;
        end else begin
            int top;
            top = -1;
            for (int i = 7; i >= 0; i--)
                if (top < 0 && m_req[i] == 0) top = i;
            m_irq = 0;
            if (stat_we) begin
                m_stat = int'(stat_lvl); m_grp = int'(stat_grp); m_lock = 0; m_enlg = 1;
            end else if (m_lock == 0 && chain_en_in && top >= 0 && (m_grp == 0 || top > m_stat)) begin
                m_level = top; m_lock = 1; m_enlg = 0; m_irq = 1;
            end
            if (req_we) m_req[req_line] = int'(req_val);
        end
    end

    task automatic chk(string r, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, int'(irq), m_irq, "model irq");
            chk(cur_req, int'(level), m_level, "model level");
            chk(cur_req, int'(chain_en_out), m_enlg, "model chain_en_out");
        end
    end

    task automatic set_req(int ln, int v);
        @(negedge clk);
        req_we = 1'b1; req_line = 3'(ln); req_val = v[0];
        @(negedge clk);
        req_we = 1'b0;
    endtask

    task automatic write_stat(int lv, int g);
        @(negedge clk);
        stat_we = 1'b1; stat_lvl = 3'(lv); stat_grp = g[0];
        @(negedge clk);
        stat_we = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(irq), 0, "irq");
        chk("R1", int'(level), 0, "level");
        chk("R1", int'(chain_en_out), 1, "chain_en_out");

        // R7 single grant of level 3
        cur_req = "R7";
        set_req(3, 0);
        @(negedge clk);
        chk("R7", int'(irq), 1, "irq pulse");
        chk("R7", int'(level), 3, "level");
        chk("R7", int'(chain_en_out), 0, "chain_en_out");
        @(negedge clk);
        chk("R7", int'(irq), 0, "irq after pulse");

        // R9 request latched while locked, R3 highest wins after unlock
        cur_req = "R9";
        set_req(6, 0);
        idle(3);
        chk("R4", int'(level), 3, "level held while locked");
        write_stat(0, 0);
        chk("R8", int'(chain_en_out), 1, "chain released");
        @(negedge clk);
        chk("R9", int'(irq), 1, "deferred grant");
        chk("R3", int'(level), 6, "highest of 3 and 6");

        // R5 strict comparison against status 5
        cur_req = "R5";
        set_req(6, 1);
        set_req(3, 1);
        write_stat(5, 1);
        set_req(4, 0);
        set_req(5, 0);
        idle(3);
        chk("R5", int'(chain_en_out), 1, "no grant at or below status");
        chk("R5", int'(level), 6, "level unchanged");
        set_req(7, 0);
        @(negedge clk);
        chk("R5", int'(level), 7, "grant above status");

        // R6 group select clear ignores status
        cur_req = "R6";
        set_req(7, 1);
        set_req(5, 1);
        write_stat(7, 0);
        @(negedge clk);
        chk("R6", int'(irq), 1, "grant below status");
        chk("R6", int'(level), 4, "level 4");

        // R4 chain enable low blocks; R2 single-line update
        cur_req = "R4";
        chain_en_in = 1'b0;
        set_req(4, 1);
        set_req(1, 0);
        write_stat(0, 0);
        idle(3);
        chk("R4", int'(level), 4, "no grant with chain low");
        chain_en_in = 1'b1;
        cur_req = "R2";
        @(negedge clk);
        chk("R2", int'(irq), 1, "grant after chain high");
        chk("R2", int'(level), 1, "only line 1 pending");
        idle(2);
        finish_run();
    end
endmodule